// File: doc/BRIEF.md
# Stack and Interrupt Vector Sequencer

This block runs the multi-cycle memory sequences that an 8-bit processor with a 16-bit address space needs for its stack and interrupt handling. It owns the 8-bit stack pointer. The stack lives in one fixed page, 0100h to 01FFh. The block accepts several kinds of request and runs each one as a short sequence on a simple synchronous memory port:

- push or pull of a single byte;
- subroutine call and subroutine return;
- software break and return from interrupt;
- maskable and non-maskable hardware interrupt entry.

The memory port makes one access per cycle. Read data comes back on the cycle after the address is presented.

At the end of a sequence the block raises a one-cycle completion pulse. In that cycle it presents the new program counter, the new status byte and, for a pull, the byte that was read. The surrounding core supplies the current program counter, the call target, the byte to push and the live status byte. After reset the block first fetches the reset vector, and only then accepts requests.

Top module: `stk_vec_seq`

## Requirements
- R1: During reset `busy` is 1, `done` is 0 and `sp` is FFh. After reset is released, the block reads FFFCh (low byte) and FFFDh (high byte) and pulses `done`. It then presents `new_pc` = {[FFFDh],[FFFCh]}, `new_status` = 24h and `sp` = FFh.
- R2: Push (`req_op` = 0) writes `req_data` to address {01h, sp} and then decrements `sp` by one.
- R3: Pull (`req_op` = 1) increments `sp` by one, then reads {01h, sp}. The byte read appears on `pull_data`.
- R4: Call (`req_op` = 2) pushes `req_pc`+2, high byte first, and presents `new_pc` = `req_tgt`. `sp` drops by 2.
- R5: Return (`req_op` = 3) pulls the low byte, then the high byte, and presents that 16-bit value plus 1 on `new_pc`. `sp` rises by 2.
- R6: Break (`req_op` = 4) pushes `req_pc`+2 (high byte, then low byte), then pushes `cur_status` with bit 4 and bit 5 forced to 1. It then loads `new_pc` from FFFEh/FFFFh (low byte first) and presents `new_status` = `cur_status` with bit 2 set. `sp` drops by 3.
- R7: A hardware interrupt pushes `req_pc` unchanged (high byte, then low byte), then pushes `cur_status` with bit 5 set and bit 4 cleared. The vector comes from FFFAh/FFFBh for `nmi_req` and from FFFEh/FFFFh for `irq_req`. `new_status` is `cur_status` with bit 2 set.
- R8: When the block is idle, `nmi_req` wins over `irq_req`, and `irq_req` wins over `req_valid`. `irq_req` is ignored while `cur_status` bit 2 is 1.
- R9: Return from interrupt (`req_op` = 5) pulls the status byte, then the low and high program counter bytes. It presents them on `new_status` and `new_pc`. `sp` rises by 3.
- R10: `done` is a single-cycle pulse, and `busy` is 1 from the accepting edge until the last step. The block ignores requests and interrupts that arrive while it is busy, and it ignores `req_op` codes 6 and 7.
- R11: The stack pointer wraps modulo 256 within the stack page. A pull at FFh reads 0100h and leaves 00h. A push at 00h writes 0100h and leaves FFh.
- R12: Memory writes go only to the stack page, one byte per cycle. No other stack byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 3 | Request code: 0 push, 1 pull, 2 call, 3 return, 4 break, 5 return from interrupt |
| req_pc | input | 16 | Current program counter |
| req_tgt | input | 16 | Call target address |
| req_data | input | 8 | Byte to push |
| cur_status | input | 8 | Live processor status byte |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_req | input | 1 | Maskable interrupt request |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, valid the cycle after the address |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| new_pc | output | 16 | Resulting program counter |
| new_status | output | 8 | Resulting status byte |
| pull_data | output | 8 | Byte returned by a pull |
| sp | output | 8 | Stack pointer (low byte of the stack address) |

## Verification
A wrong stack pointer shows up in the stack page image after the very next push. The byte lands one address off, which a full comparison of the page catches as soon as that sequence completes. A wrong step count or byte order shows up at the `done` pulse of the same sequence. Return addresses, pulled status bytes and `new_pc` come out swapped or offset, so every sequence is checked against its own return path, for example a call followed by a return, or a break followed by a return from interrupt. A request that leaks through while the block is busy produces an extra `done` pulse, or an extra write into the stack page, within a few cycles.

// File: rtl/svs_pkg.sv
package svs_pkg;
    // Internal sequence kinds; the first six match the external request codes.
    typedef enum logic [3:0] {
        K_PUSH = 4'd0,
        K_PULL = 4'd1,
        K_CALL = 4'd2,
        K_RET  = 4'd3,
        K_BRK  = 4'd4,
        K_RTI  = 4'd5,
        K_IRQ  = 4'd6,
        K_NMI  = 4'd7,
        K_RST  = 4'd8
    } kind_e;

    localparam int ST_I = 2;   // interrupt disable bit
    localparam int ST_B = 4;   // break marker bit
    localparam int ST_U = 5;   // always-one bit in pushed status
    localparam int LAST_REQ_CODE = 5;
endpackage

// File: rtl/svs_plan.sv
module svs_plan
    import svs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int SW = 3,
    parameter logic [AW-1:0] VEC_NMI = 16'hFFFA,
    parameter logic [AW-1:0] VEC_RST = 16'hFFFC,
    parameter logic [AW-1:0] VEC_IRQ = 16'hFFFE
) (
    input  kind_e          kind,
    input  logic [SW-1:0]  step,
    input  logic [AW-1:0]  pc,
    input  logic [DW-1:0]  st,
    input  logic [DW-1:0]  dat,
    output logic [SW-1:0]  n_wr,
    output logic [SW-1:0]  n_rd,
    output logic           vec_rd,
    output logic [AW-1:0]  vec_base,
    output logic [DW-1:0]  wr_byte
);
    logic [AW-1:0] ret_addr;
    logic [DW-1:0] push_st;
    logic          hw_int;

    always_comb begin
        hw_int   = (kind == K_IRQ) || (kind == K_NMI);
        ret_addr = hw_int ? pc : pc + AW'(2);
        push_st  = st;
        push_st[ST_U] = 1'b1;
        push_st[ST_B] = (kind == K_BRK);

        n_wr     = '0;
        n_rd     = '0;
        vec_rd   = 1'b0;
        vec_base = VEC_IRQ;
        unique case (kind)
            K_PUSH:                n_wr = SW'(1);
            K_PULL:                n_rd = SW'(1);
            K_CALL:                n_wr = SW'(2);
            K_RET:                 n_rd = SW'(2);
            K_RTI:                 n_rd = SW'(3);
            K_BRK, K_IRQ, K_NMI: begin
                n_wr   = SW'(3);
                n_rd   = SW'(2);
                vec_rd = 1'b1;
                vec_base = (kind == K_NMI) ? VEC_NMI : VEC_IRQ;
            end
            default: begin
                n_rd     = SW'(2);
                vec_rd   = 1'b1;
                vec_base = VEC_RST;
            end
        endcase

        if (kind == K_PUSH) begin
            wr_byte = dat;
        end else begin
            unique case (step)
                SW'(0):  wr_byte = ret_addr[AW-1 -: DW];
                SW'(1):  wr_byte = ret_addr[DW-1:0];
                default: wr_byte = push_st;
            endcase
        end
    end
endmodule

// File: rtl/svs_result.sv
module svs_result
    import svs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [DW-1:0] RST_STATUS = 8'h24
) (
    input  kind_e          kind,
    input  logic [DW-1:0]  rb0,
    input  logic [DW-1:0]  rb1,
    input  logic [DW-1:0]  rb2,
    input  logic [AW-1:0]  tgt,
    input  logic [DW-1:0]  st_in,
    input  logic [AW-1:0]  pc_old,
    input  logic [DW-1:0]  st_old,
    input  logic [DW-1:0]  pull_old,
    output logic [AW-1:0]  pc_new,
    output logic [DW-1:0]  st_new,
    output logic [DW-1:0]  pull_new
);
    logic [DW-1:0] st_masked;

    always_comb begin
        st_masked       = st_in;
        st_masked[ST_I] = 1'b1;
        pc_new   = pc_old;
        st_new   = st_old;
        pull_new = pull_old;
        unique case (kind)
            K_PULL: pull_new = rb0;
            K_CALL: pc_new   = tgt;
            K_RET:  pc_new   = {rb1, rb0} + AW'(1);
            K_RTI: begin
                st_new = rb0;
                pc_new = {rb2, rb1};
            end
            K_BRK, K_IRQ, K_NMI: begin
                pc_new = {rb1, rb0};
                st_new = st_masked;
            end
            K_RST: begin
                pc_new = {rb1, rb0};
                st_new = RST_STATUS;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_vec_seq.sv
module stk_vec_seq
    import svs_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01,
    parameter logic [DW-1:0] RST_STATUS = 8'h24,
    parameter int MAX_WR = 3,
    parameter int MAX_RD = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_op,
    input  logic [AW-1:0] req_pc,
    input  logic [AW-1:0] req_tgt,
    input  logic [DW-1:0] req_data,
    input  logic [DW-1:0] cur_status,
    input  logic          nmi_req,
    input  logic          irq_req,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic [DW-1:0] new_status,
    output logic [DW-1:0] pull_data,
    output logic [DW-1:0] sp
);
    localparam int SW = $clog2(MAX_WR + MAX_RD + 2);

    typedef struct packed {
        logic          busy;
        kind_e         kind;
        logic [SW-1:0] step;
        logic [DW-1:0] sp;
        logic [AW-1:0] pc_in;
        logic [AW-1:0] tgt;
        logic [DW-1:0] st_in;
        logic [DW-1:0] dat_in;
        logic [DW-1:0] rb0;
        logic [DW-1:0] rb1;
        logic          done;
        logic [AW-1:0] pc_out;
        logic [DW-1:0] st_out;
        logic [DW-1:0] pull_out;
    } state_t;

    state_t q, d;

    logic [SW-1:0] n_wr, n_rd, total, rd_idx, cap_idx;
    logic          vec_rd, issue_wr, issue_rd, cap, last;
    logic [AW-1:0] vec_base, res_pc;
    logic [DW-1:0] wr_byte, rb0_e, rb1_e, res_st, res_pull;

    svs_plan #(.AW(AW), .DW(DW), .SW(SW)) plan_i (
        .kind(q.kind), .step(q.step), .pc(q.pc_in), .st(q.st_in), .dat(q.dat_in),
        .n_wr(n_wr), .n_rd(n_rd), .vec_rd(vec_rd), .vec_base(vec_base),
        .wr_byte(wr_byte)
    );

    svs_result #(.AW(AW), .DW(DW), .RST_STATUS(RST_STATUS)) res_i (
        .kind(q.kind), .rb0(rb0_e), .rb1(rb1_e), .rb2(mem_rdata),
        .tgt(q.tgt), .st_in(q.st_in), .pc_old(q.pc_out), .st_old(q.st_out),
        .pull_old(q.pull_out), .pc_new(res_pc), .st_new(res_st),
        .pull_new(res_pull)
    );

    always_comb begin
        total    = n_wr + n_rd + SW'(n_rd != '0);
        rd_idx   = q.step - n_wr;
        cap_idx  = q.step - n_wr - SW'(1);
        issue_wr = q.busy && (q.step < n_wr);
        issue_rd = q.busy && (q.step >= n_wr) && (q.step < n_wr + n_rd);
        cap      = q.busy && (q.step > n_wr) && (q.step <= n_wr + n_rd);
        last     = q.busy && (q.step == total - SW'(1));
        rb0_e    = (cap && cap_idx == SW'(0)) ? mem_rdata : q.rb0;
        rb1_e    = (cap && cap_idx == SW'(1)) ? mem_rdata : q.rb1;

        mem_we    = issue_wr;
        mem_wdata = issue_wr ? wr_byte : '0;
        mem_addr  = '0;
        if (issue_wr)
            mem_addr = {STACK_PAGE, q.sp};
        else if (issue_rd)
            mem_addr = vec_rd ? vec_base + AW'(rd_idx) : {STACK_PAGE, q.sp + DW'(1)};

        d      = q;
        d.done = 1'b0;
        d.rb0  = rb0_e;
        d.rb1  = rb1_e;
        if (issue_wr)
            d.sp = q.sp - DW'(1);
        else if (issue_rd && !vec_rd)
            d.sp = q.sp + DW'(1);

        if (q.busy) begin
            if (last) begin
                d.busy     = 1'b0;
                d.done     = 1'b1;
                d.step     = '0;
                d.pc_out   = res_pc;
                d.st_out   = res_st;
                d.pull_out = res_pull;
            end else begin
                d.step = q.step + SW'(1);
            end
        end else begin
            d.pc_in  = req_pc;
            d.tgt    = req_tgt;
            d.st_in  = cur_status;
            d.dat_in = req_data;
            d.step   = '0;
            if (nmi_req) begin
                d.busy = 1'b1;
                d.kind = K_NMI;
            end else if (irq_req && !cur_status[ST_I]) begin
                d.busy = 1'b1;
                d.kind = K_IRQ;
            end else if (req_valid && int'(req_op) <= LAST_REQ_CODE) begin
                d.busy = 1'b1;
                d.kind = kind_e'({1'b0, req_op});
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.busy     <= 1'b1;
            q.kind     <= K_RST;
            q.sp       <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy       = q.busy;
    assign done       = q.done;
    assign new_pc     = q.pc_out;
    assign new_status = q.st_out;
    assign pull_data  = q.pull_out;
    assign sp         = q.sp;

    // R12
    stack_page_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1 -: DW] == STACK_PAGE && busy));

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - DW'(1)));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    sp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> (sp == $past(sp)));
endmodule

// File: tb/stk_vec_seq_tb_top.sv
`timescale 1ns/1ps
module stk_vec_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_pc = '0;
    logic [15:0] req_tgt = '0;
    logic [7:0]  req_data = '0;
    logic [7:0]  cur_status = '0;
    logic        nmi_req = 1'b0;
    logic        irq_req = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done;
    logic [15:0] new_pc;
    logic [7:0]  new_status, pull_data, sp;

    always #2.5 clk = ~clk;

    stk_vec_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_pc(req_pc), .req_tgt(req_tgt), .req_data(req_data),
        .cur_status(cur_status), .nmi_req(nmi_req), .irq_req(irq_req),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .new_pc(new_pc),
        .new_status(new_status), .pull_data(pull_data), .sp(sp)
    );

    // memory model: stack page and top page only
    logic [7:0] mem_stk [256];
    logic [7:0] mem_top [256];
    logic [7:0] ref_stk [256];
    logic [7:0] exp_sp;

    always @(posedge clk) begin
        if (mem_we && mem_addr[15:8] == 8'h01) mem_stk[mem_addr[7:0]] = mem_wdata;
        if (mem_addr[15:8] == 8'h01)      mem_rdata <= mem_stk[mem_addr[7:0]];
        else if (mem_addr[15:8] == 8'hFF) mem_rdata <= mem_top[mem_addr[7:0]];
        else                              mem_rdata <= 8'h00;
    end

    int n_cmp = 0;
    int n_bad = 0;

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", rq, act, exp);
        end
    endtask

    typedef struct {
        string       rq;
        bit          c_pc;
        logic [15:0] pc;
        bit          c_st;
        logic [7:0]  st;
        bit          c_dat;
        logic [7:0]  dat;
        logic [7:0]  sp;
    } exp_t;

    exp_t sbq[$];

    // monitor: compare results at each completion pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                check("R10 unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (e.c_pc)  check({e.rq, " pc"}, new_pc, e.pc);
                if (e.c_st)  check({e.rq, " status"}, new_status, e.st);
                if (e.c_dat) check({e.rq, " data"}, pull_data, e.dat);
                check({e.rq, " sp"}, sp, e.sp);
            end
        end
    end

    function automatic void ref_push(logic [7:0] b);
        ref_stk[exp_sp] = b;
        exp_sp = exp_sp - 8'd1;
    endfunction

    function automatic logic [7:0] ref_pull();
        exp_sp = exp_sp + 8'd1;
        return ref_stk[exp_sp];
    endfunction

    task automatic expect_res(string rq, bit cp, logic [15:0] pc, bit cs,
                              logic [7:0] st, bit cd, logic [7:0] dat);
        exp_t e;
        e.rq = rq; e.c_pc = cp; e.pc = pc; e.c_st = cs; e.st = st;
        e.c_dat = cd; e.dat = dat; e.sp = exp_sp;
        sbq.push_back(e);
    endtask

    task automatic wait_idle();
        while (busy || done) @(negedge clk);
    endtask

    task automatic drive(bit v, logic [2:0] op, logic [15:0] pc, logic [15:0] tgt,
                         logic [7:0] dat, bit nmi, bit irq);
        req_valid = v; req_op = op; req_pc = pc; req_tgt = tgt;
        req_data = dat; nmi_req = nmi; irq_req = irq;
        @(negedge clk);
        req_valid = 1'b0; nmi_req = 1'b0; irq_req = 1'b0;
    endtask

    task automatic check_mem(string rq);
        int bad = 0;
        for (int i = 0; i < 256; i++) if (mem_stk[i] !== ref_stk[i]) bad++;
        check({rq, " stack page image"}, bad, 0);
    endtask

    task automatic finish_op(string rq);
        int guard = 0;
        while (!done && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        check({rq, " completion seen"}, done, 1'b1);
        @(negedge clk);
        check_mem(rq);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem_stk[i] = 8'h00; ref_stk[i] = 8'h00; mem_top[i] = 8'h00;
        end
        mem_stk[0] = 8'h5A; ref_stk[0] = 8'h5A;
        mem_top[8'hFA] = 8'h23; mem_top[8'hFB] = 8'hC1;
        mem_top[8'hFC] = 8'h42; mem_top[8'hFD] = 8'h80;
        mem_top[8'hFE] = 8'h55; mem_top[8'hFF] = 8'h9A;
        exp_sp = 8'hFF;

        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy in reset", busy, 1'b1);
        check("R1 done in reset", done, 1'b0);
        check("R1 sp in reset", sp, 8'hFF);
        expect_res("R1 reset vector", 1, 16'h8042, 1, 8'h24, 0, 8'h00);
        rst_n = 1'b1;
        finish_op("R1");

        // R3 + R11: pull at FFh wraps to 00h and reads 0100h
        wait_idle();
        begin logic [7:0] b; b = ref_pull();
            expect_res("R11 pull wrap", 0, 0, 0, 0, 1, b); end
        drive(1, 3'd1, 0, 0, 0, 0, 0);
        finish_op("R11");

        // R2 + R11: push at 00h writes 0100h, sp -> FFh
        wait_idle();
        ref_push(8'h3C);
        expect_res("R11 push wrap", 0, 0, 0, 0, 0, 0);
        drive(1, 3'd0, 0, 0, 8'h3C, 0, 0);
        finish_op("R11");

        wait_idle();
        ref_push(8'h11);
        expect_res("R2 push", 0, 0, 0, 0, 0, 0);
        drive(1, 3'd0, 0, 0, 8'h11, 0, 0);
        check("R10 busy after accept", busy, 1'b1);
        finish_op("R2");
        wait_idle();
        ref_push(8'h22);
        expect_res("R2 push", 0, 0, 0, 0, 0, 0);
        drive(1, 3'd0, 0, 0, 8'h22, 0, 0);
        finish_op("R2");

        // R3 pull returns last pushed
        wait_idle();
        begin logic [7:0] b; b = ref_pull();
            expect_res("R3 pull", 0, 0, 0, 0, 1, b); end
        drive(1, 3'd1, 0, 0, 0, 0, 0);
        finish_op("R3");

        // R4 call
        wait_idle();
        ref_push(8'h12); ref_push(8'h36);
        expect_res("R4 call", 1, 16'h4000, 0, 0, 0, 0);
        drive(1, 3'd2, 16'h1234, 16'h4000, 0, 0, 0);
        finish_op("R4");

        // R5 return
        wait_idle();
        begin logic [7:0] lo, hi; lo = ref_pull(); hi = ref_pull();
            expect_res("R5 return", 1, {hi, lo} + 16'd1, 0, 0, 0, 0); end
        drive(1, 3'd3, 0, 0, 0, 0, 0);
        finish_op("R5");

        // R6 break
        wait_idle();
        cur_status = 8'h81;
        ref_push(8'h20); ref_push(8'h02); ref_push(8'hB1);
        expect_res("R6 break", 1, 16'h9A55, 1, 8'h85, 0, 0);
        drive(1, 3'd4, 16'h2000, 0, 0, 0, 0);
        finish_op("R6");

        // R9 return from interrupt
        wait_idle();
        begin logic [7:0] s, lo, hi; s = ref_pull(); lo = ref_pull(); hi = ref_pull();
            expect_res("R9 rti", 1, {hi, lo}, 1, s, 0, 0); end
        drive(1, 3'd5, 0, 0, 0, 0, 0);
        finish_op("R9");

        // R8 + R7: nmi beats irq and request
        wait_idle();
        cur_status = 8'h10;
        ref_push(8'h34); ref_push(8'h56); ref_push(8'h20);
        expect_res("R8 nmi priority", 1, 16'hC123, 1, 8'h14, 0, 0);
        drive(1, 3'd0, 16'h3456, 0, 8'hEE, 1, 1);
        finish_op("R8");

        // R8: irq masked by bit 2, push goes ahead
        wait_idle();
        cur_status = 8'h04;
        ref_push(8'h77);
        expect_res("R8 masked irq", 0, 0, 0, 0, 0, 0);
        drive(1, 3'd0, 16'h5555, 0, 8'h77, 0, 1);
        finish_op("R8");

        // R7 maskable interrupt
        wait_idle();
        cur_status = 8'h40;
        ref_push(8'h50); ref_push(8'h00); ref_push(8'h60);
        expect_res("R7 irq entry", 1, 16'h9A55, 1, 8'h44, 0, 0);
        drive(1, 3'd0, 16'h5000, 0, 8'hEE, 0, 1);
        finish_op("R7");

        // R10: requests while busy are ignored
        wait_idle();
        ref_push(8'h01); ref_push(8'h02);
        expect_res("R10 call under traffic", 1, 16'h6000, 0, 0, 0, 0);
        drive(1, 3'd2, 16'h0100, 16'h6000, 0, 0, 0);
        drive(1, 3'd0, 0, 0, 8'h99, 1, 0);
        finish_op("R10");
        repeat (8) @(negedge clk);
        check("R10 sp after ignored traffic", sp, exp_sp);
        check_mem("R10");

        // R10: undefined request codes
        wait_idle();
        drive(1, 3'd6, 0, 0, 8'hAA, 0, 0);
        drive(1, 3'd7, 0, 0, 8'hAA, 0, 0);
        repeat (6) @(negedge clk);
        check("R10 code 6/7 busy", busy, 1'b0);
        check("R10 code 6/7 sp", sp, exp_sp);
        check_mem("R12");
        check("R10 queue drained", sbq.size(), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R10 watchdog: actual hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule